// File: doc/BRIEF.md
# SPI Mode Control and Interrupt Unit

This unit is the control and interrupt part of an 8-bit SPI peripheral. Software configures it through one 8-bit control register on a simple register bus. That bus has a single-cycle write strobe, combinational read data, and separate select lines for the control register and the status register. The control register drives the mode outputs used by the shift engine and the pin drivers: enable, master/slave select, SCK idle level, clock phase and open-drain drive. Those two blocks are outside this unit.

The unit holds a status IRQ flag and turns it into a registered interrupt request for the interrupt controller. Software can force the flag by writing a control word whose force bit is set. This gives an interrupt that behaves like a transmit-empty event. While the SPI is disabled, a timer select bit turns the baud-rate generator into a free-running down-counter. The counter sets the flag each time it times out. Its reload value comes in on a port.

Top module: `spi_mode_unit`

## Requirements
- R1: After reset, every control bit is 0, the status IRQ flag is 0 and irqOut is 0.
- R2: Control bit positions are: 7 interrupt enable, 6 force, 5 timer select, 4 clock phase, 3 SCK idle high, 2 open-drain, 1 master, 0 enable. A control write stores wrData, and the value reads back with selCtrl. The outputs clkPhase, sckIdleHigh, openDrain, masterMode and spiEnable each follow their bit.
- R3: irqOut is a registered level. In each cycle it equals (interrupt enable AND status IRQ flag) from the cycle before. With interrupt enable at 0, irqOut stays 0.
- R4: A control write with bit 6 set sets the status IRQ flag at the same clock edge. The status register reads as {flag, 7'b0}.
- R5: A status write with bit 7 set clears the flag and control bit 6. A status write with bit 7 clear has no effect.
- R6: The timer runs (timerRun=1) only while control bit 0 is 0 and bit 5 is 1. While bit 0 is 1, bit 5 has no effect and the timer never sets the flag.
- R7: While the timer runs, it counts down once per clock from brgReload. It sets the flag in the cycle after the count reaches zero, then reloads. The first request appears on irqOut brgReload+3 clocks after the enabling write, and later time-outs come every brgReload+1 clocks.
- R8: When a set (force write or time-out) and a status clear land in the same cycle, the flag ends up set. A control write in that same cycle stores its own bit 6.
- R9: rdData gives the control register when selCtrl is high, otherwise the status register when selStat is high, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| selCtrl | input | 1 | Selects the control register |
| selStat | input | 1 | Selects the status register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data |
| brgReload | input | 16 | Timer reload value |
| spiEnable | output | 1 | SPI enable |
| masterMode | output | 1 | 1 = master, 0 = slave |
| sckIdleHigh | output | 1 | SCK idle level |
| clkPhase | output | 1 | Clock phase select |
| openDrain | output | 1 | Open-drain drive for all four SPI pins |
| timerRun | output | 1 | Baud-rate generator is running as a timer |
| irqOut | output | 1 | Interrupt request level |

## Verification
The hardest case to reach is a flag set and a status clear in the same clock. A time-out lands on a clock edge the bench does not directly choose.

The stimulus sets the reload value to zero and enables the timer, so a time-out occurs on every clock. Any status clear then collides with a set.

A second collision comes from one write that raises both selects, with the force bit and the clear bit both set in the data. A behavioural model tracks the flag, the counter and the registered request, and they are compared against the ports on every cycle.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;
  localparam int CTRL_W      = 8;
  localparam int BIT_IRQEN   = 7;
  localparam int BIT_FORCE   = 6;
  localparam int BIT_TMRSEL  = 5;
  localparam int BIT_PHASE   = 4;
  localparam int BIT_IDLEHI  = 3;
  localparam int BIT_OPENDR  = 2;
  localparam int BIT_MASTER  = 1;
  localparam int BIT_ENABLE  = 0;
  localparam int STAT_IRQBIT = 7;

  typedef struct packed {
    logic              ctrlWr;
    logic              forceSet;
    logic              irqClr;
    logic [CTRL_W-1:0] wrVal;
  } regStb_t;
endpackage

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
  import spi_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wrEn,
  input  logic              selCtrl,
  input  logic              selStat,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ctrlQ,
  input  logic              irqQ,
  output regStb_t           stb,
  output logic [DATA_W-1:0] rdData
);
  logic ctrlHit;
  logic statHit;

  assign ctrlHit = wrEn & selCtrl;
  assign statHit = wrEn & selStat;

  always_comb begin
    stb          = '0;
    stb.ctrlWr   = ctrlHit;
    stb.forceSet = ctrlHit & wrData[BIT_FORCE];
    stb.irqClr   = statHit & wrData[STAT_IRQBIT];
    stb.wrVal    = wrData;
  end

  always_comb begin
    rdData = '0;
    if (selCtrl) begin
      rdData = ctrlQ;
    end else if (selStat) begin
      rdData[STAT_IRQBIT] = irqQ;
    end
  end
endmodule

// File: rtl/spi_brg_timer.sv
module spi_brg_timer #(
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  output logic                hit
);
  logic [RELOAD_W-1:0] cnt;

  assign hit = run && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!run || hit) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_mode_dpath.sv
module spi_mode_dpath
  import spi_mode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStb_t             stb,
  input  logic [RELOAD_W-1:0] brgReload,
  output logic [DATA_W-1:0]   ctrlQ,
  output logic                irqQ,
  output logic                timerRun,
  output logic                timeoutHit,
  output logic                irqOut
);
  logic irqSet;

  assign timerRun = !ctrlQ[BIT_ENABLE] && ctrlQ[BIT_TMRSEL];
  assign irqSet   = stb.forceSet | timeoutHit;

  spi_brg_timer #(.RELOAD_W(RELOAD_W)) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .run   (timerRun),
    .reload(brgReload),
    .hit   (timeoutHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (stb.ctrlWr) begin
      ctrlQ <= stb.wrVal;
    end else if (stb.irqClr) begin
      ctrlQ[BIT_FORCE] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (irqSet) begin
      irqQ <= 1'b1;
    end else if (stb.irqClr) begin
      irqQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else begin
      irqOut <= ctrlQ[BIT_IRQEN] & irqQ;
    end
  end
endmodule

// File: rtl/spi_mode_unit.sv
module spi_mode_unit
  import spi_mode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                selCtrl,
  input  logic                selStat,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [RELOAD_W-1:0] brgReload,
  output logic                spiEnable,
  output logic                masterMode,
  output logic                sckIdleHigh,
  output logic                clkPhase,
  output logic                openDrain,
  output logic                timerRun,
  output logic                irqOut
);
  regStb_t           stb;
  logic [DATA_W-1:0] ctrlQ;
  logic              irqQ;
  logic              timeoutHit;

  spi_mode_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn   (wrEn),
    .selCtrl(selCtrl),
    .selStat(selStat),
    .wrData (wrData),
    .ctrlQ  (ctrlQ),
    .irqQ   (irqQ),
    .stb    (stb),
    .rdData (rdData)
  );

  spi_mode_dpath #(.DATA_W(DATA_W), .RELOAD_W(RELOAD_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .brgReload (brgReload),
    .ctrlQ     (ctrlQ),
    .irqQ      (irqQ),
    .timerRun  (timerRun),
    .timeoutHit(timeoutHit),
    .irqOut    (irqOut)
  );

  assign spiEnable   = ctrlQ[BIT_ENABLE];
  assign masterMode  = ctrlQ[BIT_MASTER];
  assign sckIdleHigh = ctrlQ[BIT_IDLEHI];
  assign clkPhase    = ctrlQ[BIT_PHASE];
  assign openDrain   = ctrlQ[BIT_OPENDR];
endmodule

// File: rtl/spi_mode_chk.sv
module spi_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       selCtrl,
  input logic       selStat,
  input logic [7:0] wrData,
  input logic [7:0] ctrlQ,
  input logic       irqQ,
  input logic       timeoutHit,
  input logic       timerRun,
  input logic       spiEnable,
  input logic       irqOut
);
  // R2: a control write is stored as written
  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selCtrl) |=> (ctrlQ == $past(wrData)));

  // R3: the request follows enable AND flag one cycle later
  a_r3_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[7] && irqQ) |=> irqOut);
  a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[7]) |=> !irqOut);

  // R4: the force bit sets the flag
  a_r4_force_sets: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selCtrl && wrData[6]) |=> irqQ);

  // R5: the clear drops the flag when nothing sets it
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selStat && wrData[7] && !timeoutHit && !(selCtrl && wrData[6]))
      |=> (!irqQ && !ctrlQ[6]));

  // R6: the timer never runs while the SPI is enabled
  a_r6_timer_gated: assert property (@(posedge clk) disable iff (!rstN)
    spiEnable |-> (!timerRun && !timeoutHit));

  // R8: a time-out beats a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutHit && wrEn && selStat && wrData[7]) |=> irqQ);
endmodule

bind spi_mode_unit spi_mode_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .selCtrl   (selCtrl),
  .selStat   (selStat),
  .wrData    (wrData),
  .ctrlQ     (ctrlQ),
  .irqQ      (irqQ),
  .timeoutHit(timeoutHit),
  .timerRun  (timerRun),
  .spiEnable (spiEnable),
  .irqOut    (irqOut)
);

// File: tb/test_spi_mode_unit.sv
`timescale 1ns/1ps
module test_spi_mode_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        selCtrl = 1'b0;
  logic        selStat = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic [15:0] brgReload = 16'd3;
  logic        spiEnable, masterMode, sckIdleHigh, clkPhase, openDrain;
  logic        timerRun, irqOut;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  spi_mode_unit i_spi_mode_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .selCtrl(selCtrl), .selStat(selStat),
    .wrData(wrData), .rdData(rdData), .brgReload(brgReload),
    .spiEnable(spiEnable), .masterMode(masterMode), .sckIdleHigh(sckIdleHigh),
    .clkPhase(clkPhase), .openDrain(openDrain), .timerRun(timerRun), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [7:0] mCtrl = 8'h00;
  bit         mIrq = 0;
  bit         mIrqOut = 0;
  int         mCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 8'h00; mIrq = 0; mIrqOut = 0; mCnt = 0;
    end else begin
      bit on, hit, setReq, clrReq;
      on     = !mCtrl[0] && mCtrl[5];
      hit    = on && (mCnt == 0);
      setReq = (wrEn && selCtrl && wrData[6]) || hit;
      clrReq = wrEn && selStat && wrData[7];
      mIrqOut = mCtrl[7] && mIrq;
      if (!on || hit) mCnt = int'(brgReload);
      else            mCnt = mCnt - 1;
      if (setReq)      mIrq = 1;
      else if (clrReq) mIrq = 0;
      if (wrEn && selCtrl) mCtrl = wrData;
      else if (clrReq)     mCtrl[6] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] expRd;
      expRd = selCtrl ? mCtrl : (selStat ? {mIrq, 7'b0} : 8'h00);
      chk("R9 rdData", int'(rdData), int'(expRd));
      chk("R2 spiEnable", int'(spiEnable), int'(mCtrl[0]));
      chk("R2 masterMode", int'(masterMode), int'(mCtrl[1]));
      chk("R2 openDrain", int'(openDrain), int'(mCtrl[2]));
      chk("R2 sckIdleHigh", int'(sckIdleHigh), int'(mCtrl[3]));
      chk("R2 clkPhase", int'(clkPhase), int'(mCtrl[4]));
      chk("R6 timerRun", int'(timerRun), int'(!mCtrl[0] && mCtrl[5]));
      chk("R3 irqOut", int'(irqOut), int'(mIrqOut));
    end
  end

  task automatic busWrite(input bit c, input bit s, input logic [7:0] d);
    @(posedge clk); #2;
    wrEn = 1'b1; selCtrl = c; selStat = s; wrData = d;
    @(posedge clk); #2;
    wrEn = 1'b0; selCtrl = 1'b0; selStat = 1'b0; wrData = 8'h00;
  endtask

  task automatic busRead(input bit c, input bit s, output logic [7:0] v);
    @(posedge clk); #2;
    wrEn = 1'b0; selCtrl = c; selStat = s;
    @(negedge clk);
    v = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    // R1 reset state
    @(posedge clk); @(negedge clk);
    chk("R1 irqOut", int'(irqOut), 0);
    chk("R1 spiEnable", int'(spiEnable), 0);
    chk("R1 timerRun", int'(timerRun), 0);
    rstN = 1'b1;
    busRead(1, 0, v); chk("R1 ctrl", int'(v), 0);
    busRead(0, 1, v); chk("R1 status", int'(v), 0);

    // R2 field positions
    busWrite(1, 0, 8'h1E);
    busRead(1, 0, v); chk("R2 readback", int'(v), 8'h1E);
    chk("R2 phase", int'(clkPhase), 1);
    chk("R2 idle", int'(sckIdleHigh), 1);
    chk("R2 opendrain", int'(openDrain), 1);
    chk("R2 master", int'(masterMode), 1);
    chk("R2 enable", int'(spiEnable), 0);
    busWrite(1, 0, 8'h01);
    busRead(1, 0, v); chk("R2 readback2", int'(v), 8'h01);

    // R4 force with interrupts masked, R3 masked request
    busWrite(1, 0, 8'h41);
    busRead(0, 1, v); chk("R4 status set", int'(v), 8'h80);
    chk("R3 masked", int'(irqOut), 0);

    // R5 zero write ignored, then clear
    busWrite(0, 1, 8'h7F);
    busRead(0, 1, v); chk("R5 no clear", int'(v), 8'h80);
    busWrite(0, 1, 8'h80);
    busRead(0, 1, v); chk("R5 cleared", int'(v), 8'h00);
    busRead(1, 0, v); chk("R5 force cleared", int'(v), 8'h01);

    // R3 enabled request
    busWrite(1, 0, 8'hC1);
    busRead(0, 0, v); chk("R3 irqOut high", int'(irqOut), 1);
    chk("R9 no select", int'(v), 0);
    busWrite(0, 1, 8'h80);
    idle(2);
    chk("R3 irqOut low", int'(irqOut), 0);

    // R7 timer period
    brgReload = 16'd3;
    busWrite(1, 0, 8'hA0);
    n = 0;
    for (int i = 1; i < 50; i++) begin
      @(negedge clk);
      if (irqOut) begin n = i; break; end
    end
    chk("R7 first timeout", n, 6);

    // R6 timer select ignored while enabled
    busWrite(1, 0, 8'hA1);
    busWrite(0, 1, 8'h80);
    idle(20);
    chk("R6 no timeout", int'(irqOut), 0);
    busRead(0, 1, v); chk("R6 status", int'(v), 0);
    chk("R6 timerRun", int'(timerRun), 0);

    // R8 time-out beats clear
    brgReload = 16'd0;
    busWrite(1, 0, 8'h20);
    idle(2);
    busWrite(0, 1, 8'h80);
    busRead(0, 1, v); chk("R8 timeout wins", int'(v), 8'h80);

    // R8 force beats clear in one write
    busWrite(1, 0, 8'h01);
    busWrite(0, 1, 8'h80);
    busRead(0, 1, v); chk("R8 pre clear", int'(v), 8'h00);
    busWrite(1, 1, 8'hC0);
    busRead(0, 1, v); chk("R8 force wins", int'(v), 8'h80);
    busRead(1, 0, v); chk("R8 ctrl stored", int'(v), 8'hC0);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule